// File: doc/BRIEF.md
# Dual-Clock Bus-to-Pad I/O Buffer Shell

This block is the fixed shell around a replaceable pad-facing protocol core. On the host side it is a 32-bit bus slave that accepts single read and write transfers in the system clock domain. On the pad side it runs on a separate interface clock. Between the two domains sit a transmit queue and a receive queue, each 256 words of 32 bits (1 KB). Their read and write pointers cross the boundary in Gray code through multi-stage synchronisers.

Software governs the shell through a control word and reads a status word and a fill-level word. It pushes words by writing the transmit data index and pops words by reading the receive data index. The protocol core is stood in for by a loopback stub. While the interface is enabled, the stub moves each transmit word to the receive queue. It also presents that word on the pad data outputs, with a one-cycle strobe.

A soft reset clears both queues and the sticky error flags. It does this through a request/acknowledge exchange that resets the pointer logic in both clock domains.

Top module: `padio_shell`

## Requirements
- R1: After reset, CTRL (index 0) reads 0, STATUS (index 1) reads 0x5 (bit0 transmit empty, bit2 receive empty), LEVELS (index 2) reads 0, and pad_oe is low.
- R2: A bus write to index 3 while the transmit queue is not full appends the word. LEVELS bits [15:0] (transmit fill) then increase by one.
- R3: After 256 words the transmit queue reports full (STATUS bit1). Another write to index 3 is dropped, the fill level stays 256, and the sticky overflow flag (STATUS bit4) is set and stays set.
- R4: With the interface enabled, words travel to the receive queue in the order written. LEVELS bits [31:16] give the receive fill, and STATUS bit3 flags it full at 256. A read of index 4 returns the oldest received word and removes it.
- R5: A read of index 4 while the receive queue is empty returns 0 and sets the sticky underflow flag (STATUS bit5).
- R6: Writing CTRL with bit1 set starts a soft reset. While it runs, STATUS bit6 (busy) reads 1. When it ends, both queues are empty, STATUS bits 4 and 5 are clear, and CTRL bit1 reads 0. No word queued before the soft reset is delivered after it.
- R7: pad_oe follows CTRL bit0. Every word the stub transfers appears on pad_dout together with a one-interface-cycle pad_strobe pulse.
- R8: While CTRL bit0 is 0, no word leaves the transmit queue: its fill level holds, no strobe occurs, and pad_dout holds its value.
- R9: CTRL bit0 reads back as written. A read of the transmit data index returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System bus clock |
| rst_sys_n | input | 1 | Active-low synchronous reset, system domain |
| bus_sel | input | 1 | Transfer select, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_idx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the access |
| clk_if | input | 1 | Interface (pad) clock |
| rst_if_n | input | 1 | Active-low synchronous reset, interface domain |
| pad_dout | output | 32 | Last word sent toward the pads |
| pad_oe | output | 1 | Pad output enable |
| pad_strobe | output | 1 | One-cycle pulse per word sent |

## Verification
The bench builds the shell with its default parameters: 256-entry queues, two synchroniser stages and a 32-bit bus. This makes the true full boundary reachable, both for the overflow drop and for a receive queue filled to exactly its capacity. The two clocks are unrelated in period, so the Gray pointers and the soft-reset handshake are exercised across a real phase drift. The ordering check drains all 256 looped-back words and compares each against a computed pattern.

// File: rtl/padio_pkg.sv
`timescale 1ns/1ps
package padio_pkg;
   typedef enum logic [2:0] {
      IDX_CTRL = 3'd0,
      IDX_STAT = 3'd1,
      IDX_LVL  = 3'd2,
      IDX_TXD  = 3'd3,
      IDX_RXD  = 3'd4
   } padio_idx_e;

   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_FLUSH_BIT = 1;
endpackage

// File: rtl/padio_sync.sv
`timescale 1ns/1ps
module padio_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("padio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/padio_cdc_fifo.sv
`timescale 1ns/1ps
module padio_cdc_fifo #(
   parameter int W    = 32,
   parameter int AW   = 8,
   parameter int SYNC = 2
) (
   input  logic          wclk,
   input  logic          wrst,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   output logic          wfull,
   output logic [AW:0]   wlevel,
   input  logic          rclk,
   input  logic          rrst,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          rempty,
   output logic [AW:0]   rlevel
);
   localparam int          DEPTH    = 1 << AW;
   localparam logic [AW:0] FULL_LVL = {1'b1, {AW{1'b0}}};

   function automatic logic [AW:0] to_gray(input logic [AW:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [AW:0] from_gray(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wbin, wgray, wbin_nxt, rgray_at_w;
   logic [AW:0]  rbin, rgray, rbin_nxt, wgray_at_r;
   logic         do_push, do_pop;

   // write side
   assign do_push  = push && !wfull;
   assign wbin_nxt = wbin + 1'b1;

   always_ff @(posedge wclk) begin
      if (wrst) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (do_push) begin
         wbin  <= wbin_nxt;
         wgray <= to_gray(wbin_nxt);
      end
   end

   always_ff @(posedge wclk) begin
      if (do_push) mem[wbin[AW-1:0]] <= wdata;
   end

   padio_sync #(.W(AW + 1), .STAGES(SYNC)) u_rptr_sync (
      .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_at_w));

   assign wlevel = wbin - from_gray(rgray_at_w);
   assign wfull  = (wlevel == FULL_LVL);

   // read side
   assign do_pop   = pop && !rempty;
   assign rbin_nxt = rbin + 1'b1;

   always_ff @(posedge rclk) begin
      if (rrst) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (do_pop) begin
         rbin  <= rbin_nxt;
         rgray <= to_gray(rbin_nxt);
      end
   end

   padio_sync #(.W(AW + 1), .STAGES(SYNC)) u_wptr_sync (
      .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_at_r));

   assign rlevel = from_gray(wgray_at_r) - rbin;
   assign rempty = (rlevel == '0);
   assign rdata  = mem[rbin[AW-1:0]];

   AST_WGRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (wrst)
      $countones(wgray ^ $past(wgray)) <= 1); // R4
   AST_RGRAY_ONE_STEP: assert property (@(posedge rclk) disable iff (rrst)
      $countones(rgray ^ $past(rgray)) <= 1); // R4
   AST_NO_OVERFILL: assert property (@(posedge wclk) disable iff (wrst)
      wlevel <= FULL_LVL); // R3
endmodule

// File: rtl/padio_loop_stub.sv
`timescale 1ns/1ps
module padio_loop_stub #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         tx_empty,
   input  logic [W-1:0] tx_data,
   output logic         tx_pop,
   input  logic         rx_full,
   output logic         rx_push,
   output logic [W-1:0] rx_data,
   output logic [W-1:0] pad_dout,
   output logic         pad_oe,
   output logic         pad_strobe
);
   assign tx_pop  = en && !tx_empty && !rx_full;
   assign rx_push = tx_pop;
   assign rx_data = tx_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         pad_dout   <= '0;
         pad_oe     <= 1'b0;
         pad_strobe <= 1'b0;
      end else begin
         pad_oe     <= en;
         pad_strobe <= tx_pop;
         if (tx_pop) pad_dout <= tx_data;
      end
   end

   AST_STROBE_CARRIES_WORD: assert property (@(posedge clk) disable iff (rst)
      tx_pop |=> (pad_strobe && pad_dout == $past(tx_data))); // R7
endmodule

// File: rtl/padio_shell.sv
`timescale 1ns/1ps
module padio_shell #(
   parameter int BUS_W       = 32,
   parameter int DEPTH_LOG2  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_sys,
   input  logic             rst_sys_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [2:0]       bus_idx,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             clk_if,
   input  logic             rst_if_n,
   output logic [BUS_W-1:0] pad_dout,
   output logic             pad_oe,
   output logic             pad_strobe
);
   import padio_pkg::*;

   localparam int          LVL_W    = DEPTH_LOG2 + 1;
   localparam logic [LVL_W-1:0] FULL_LVL = {1'b1, {DEPTH_LOG2{1'b0}}};

   if (BUS_W != 32) begin : g_bad_bus
      $error("padio_shell: status and level layout needs BUS_W == 32");
   end
   if (DEPTH_LOG2 < 2 || DEPTH_LOG2 > 15) begin : g_bad_depth
      $error("padio_shell: DEPTH_LOG2 must lie in 2..15");
   end

   logic sys_rst, if_rst;
   logic flush_hold, flush_if, flush_ack, busy;
   logic ctrl_en, en_if, ovf_q, udf_q;
   logic wr_ctrl, wr_txd, rd_rxd, tx_push, rx_pop;
   logic tx_full_s, tx_empty_s, rx_full_s, rx_empty_s;
   logic [LVL_W-1:0] tx_lvl_s, rx_lvl_s, unused_tx_rlvl, unused_rx_wlvl;
   logic [BUS_W-1:0] rx_data_s, tx_data_i, rx_data_i, rd_mux;
   logic tx_pop_i, tx_empty_i, rx_push_i, rx_full_i;
   padio_idx_e idx;

   // soft-reset request / acknowledge across the boundary
   padio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_flush_fwd (
      .clk(clk_if), .rst(!rst_if_n), .d(flush_hold), .q(flush_if));
   padio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_flush_back (
      .clk(clk_sys), .rst(!rst_sys_n), .d(flush_if), .q(flush_ack));

   assign sys_rst = !rst_sys_n || flush_hold;
   assign if_rst  = !rst_if_n || flush_if;
   assign busy    = flush_hold || flush_ack;

   padio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_en_sync (
      .clk(clk_if), .rst(if_rst), .d(ctrl_en), .q(en_if));

   // bus decode
   assign idx     = padio_idx_e'(bus_idx);
   assign wr_ctrl = bus_sel && bus_wr && idx == IDX_CTRL;
   assign wr_txd  = bus_sel && bus_wr && idx == IDX_TXD;
   assign rd_rxd  = bus_sel && !bus_wr && idx == IDX_RXD;
   assign tx_push = wr_txd && !tx_full_s;
   assign rx_pop  = rd_rxd && !rx_empty_s;

   always_ff @(posedge clk_sys) begin
      if (!rst_sys_n) begin
         ctrl_en    <= 1'b0;
         flush_hold <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_en <= bus_wdata[CTRL_EN_BIT];
         if (flush_hold && flush_ack)
            flush_hold <= 1'b0;
         else if (wr_ctrl && bus_wdata[CTRL_FLUSH_BIT] && !busy)
            flush_hold <= 1'b1;
      end
   end

   always_ff @(posedge clk_sys) begin
      if (sys_rst) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         if (wr_txd && tx_full_s)  ovf_q <= 1'b1;
         if (rd_rxd && rx_empty_s) udf_q <= 1'b1;
      end
   end

   assign tx_empty_s = (tx_lvl_s == '0);
   assign rx_full_s  = (rx_lvl_s == FULL_LVL);

   always_comb begin
      unique case (idx)
         IDX_CTRL: rd_mux = BUS_W'(ctrl_en);
         IDX_STAT: rd_mux = BUS_W'({busy, udf_q, ovf_q, rx_full_s,
                                   rx_empty_s, tx_full_s, tx_empty_s});
         IDX_LVL:  rd_mux = {16'(rx_lvl_s), 16'(tx_lvl_s)};
         IDX_RXD:  rd_mux = rx_empty_s ? '0 : rx_data_s;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_sys) begin
      if (!rst_sys_n)             bus_rdata <= '0;
      else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
   end

   // queues
   padio_cdc_fifo #(.W(BUS_W), .AW(DEPTH_LOG2), .SYNC(SYNC_STAGES)) u_txq (
      .wclk(clk_sys), .wrst(sys_rst), .push(tx_push), .wdata(bus_wdata),
      .wfull(tx_full_s), .wlevel(tx_lvl_s),
      .rclk(clk_if), .rrst(if_rst), .pop(tx_pop_i), .rdata(tx_data_i),
      .rempty(tx_empty_i), .rlevel(unused_tx_rlvl));

   padio_cdc_fifo #(.W(BUS_W), .AW(DEPTH_LOG2), .SYNC(SYNC_STAGES)) u_rxq (
      .wclk(clk_if), .wrst(if_rst), .push(rx_push_i), .wdata(rx_data_i),
      .wfull(rx_full_i), .wlevel(unused_rx_wlvl),
      .rclk(clk_sys), .rrst(sys_rst), .pop(rx_pop), .rdata(rx_data_s),
      .rempty(rx_empty_s), .rlevel(rx_lvl_s));

   padio_loop_stub #(.W(BUS_W)) u_core (
      .clk(clk_if), .rst(if_rst), .en(en_if),
      .tx_empty(tx_empty_i), .tx_data(tx_data_i), .tx_pop(tx_pop_i),
      .rx_full(rx_full_i), .rx_push(rx_push_i), .rx_data(rx_data_i),
      .pad_dout(pad_dout), .pad_oe(pad_oe), .pad_strobe(pad_strobe));

   AST_EMPTY_READ_ZERO: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
      (rd_rxd && rx_empty_s) |=> (bus_rdata == '0)); // R5
   AST_OVF_STICKY: assert property (@(posedge clk_sys) disable iff (sys_rst)
      $past(ovf_q) |-> ovf_q); // R3
   AST_FLUSH_CLEARS: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
      $rose(flush_hold) |=> (!ovf_q && !udf_q && tx_lvl_s == '0)); // R6
   AST_OFF_QUIET: assert property (@(posedge clk_if) disable iff (if_rst)
      !en_if |=> $stable(pad_dout)); // R8
endmodule

// File: tb/padio_shell_bench.sv
`timescale 1ns/1ps
module padio_shell_bench;
   localparam logic [2:0] I_CTRL = 3'd0, I_STAT = 3'd1, I_LVL = 3'd2,
                          I_TXD = 3'd3, I_RXD = 3'd4;
   // {word, expected transmit fill after pushing it}
   localparam logic [63:0] VEC [8] = '{
      {32'h0000_0001, 32'd1}, {32'hFFFF_FFFF, 32'd2},
      {32'hA5A5_5A5A, 32'd3}, {32'h8000_0000, 32'd4},
      {32'h1234_5678, 32'd5}, {32'h0F0F_F0F0, 32'd6},
      {32'hDEAD_BEEF, 32'd7}, {32'h7FFF_FFFE, 32'd8}};

   logic        clk_sys = 1'b0, clk_if = 1'b0;
   logic        rst_sys_n = 1'b0, rst_if_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_idx = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, pad_dout;
   logic        pad_oe, pad_strobe;
   int          checks = 0, errors = 0, strobes = 0;
   bit          done = 1'b0;

   always #2   clk_sys = ~clk_sys;
   always #3.5 clk_if  = ~clk_if;

   padio_shell u_padio_shell (
      .clk_sys(clk_sys), .rst_sys_n(rst_sys_n), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .clk_if(clk_if), .rst_if_n(rst_if_n),
      .pad_dout(pad_dout), .pad_oe(pad_oe), .pad_strobe(pad_strobe));

   always @(negedge clk_if) if (pad_strobe) strobes++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] i, input logic [31:0] d);
      @(negedge clk_sys);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = i; bus_wdata = d;
      @(negedge clk_sys);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] i, output logic [31:0] d);
      @(negedge clk_sys);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = i;
      @(negedge clk_sys);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk_sys);
   endtask

   function automatic logic [31:0] pat(input int k);
      return (32'(k) * 32'h0101_0103) ^ 32'hC300_0000;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #600000;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int bad, polls;
      idle(6);
      rst_sys_n = 1'b1; rst_if_n = 1'b1;
      idle(2);

      // R1 reset state
      rd(I_CTRL, v); chk("R1 ctrl", v, 32'h0);
      rd(I_STAT, v); chk("R1 status", v, 32'h5);
      rd(I_LVL, v);  chk("R1 levels", v, 32'h0);
      chk("R1 pad_oe", 32'(pad_oe), 32'h0);

      // R2 table walk with the interface disabled
      for (int k = 0; k < 8; k++) begin
         wr(I_TXD, VEC[k][63:32]);
         rd(I_LVL, v);
         chk("R2 tx fill", v, VEC[k][31:0]);
      end
      rd(I_TXD, v); chk("R9 txd reads zero", v, 32'h0);

      // R8 nothing moves while disabled
      idle(40);
      rd(I_LVL, v); chk("R8 tx fill held", v, 32'd8);
      chk("R8 no strobe", 32'(strobes), 32'd0);

      // R9 / R4 / R7 enable and loop back
      wr(I_CTRL, 32'h1);
      rd(I_CTRL, v); chk("R9 enable readback", v, 32'h1);
      idle(60);
      rd(I_LVL, v); chk("R4 levels after loop", v, 32'h0008_0000);
      chk("R7 strobe count", 32'(strobes), 32'd8);
      chk("R7 pad_dout last", pad_dout, VEC[7][63:32]);
      chk("R7 pad_oe on", 32'(pad_oe), 32'h1);
      for (int k = 0; k < 8; k++) begin
         rd(I_RXD, v);
         chk("R4 rx order", v, VEC[k][63:32]);
      end

      // R5 empty read
      rd(I_RXD, v);  chk("R5 empty read", v, 32'h0);
      rd(I_STAT, v); chk("R5 underflow flag", v, 32'h25);

      // R3 fill to capacity with the interface off
      wr(I_CTRL, 32'h0);
      idle(20);
      chk("R7 pad_oe off", 32'(pad_oe), 32'h0);
      for (int k = 0; k < 256; k++) wr(I_TXD, pat(k));
      rd(I_STAT, v); chk("R3 full", v, 32'h26);
      wr(I_TXD, 32'hBAD0_BAD0);
      rd(I_STAT, v); chk("R3 overflow flag", v, 32'h36);
      rd(I_LVL, v);  chk("R3 fill held", v, 32'd256);

      // R4 receive queue filled to capacity, drained in order
      wr(I_CTRL, 32'h1);
      idle(900);
      rd(I_STAT, v); chk("R4 rx full", v, 32'h39);
      bad = 0;
      for (int k = 0; k < 256; k++) begin
         rd(I_RXD, v);
         if (v !== pat(k)) bad++;
      end
      chk("R4 256-word order", 32'(bad), 32'd0);
      rd(I_STAT, v); chk("R3 overflow still set", v, 32'h35);

      // R6 soft reset with words pending
      wr(I_CTRL, 32'h0);
      idle(10);
      wr(I_TXD, 32'h1111_1111);
      wr(I_TXD, 32'h2222_2222);
      wr(I_TXD, 32'h3333_3333);
      wr(I_CTRL, 32'h2);
      rd(I_STAT, v); chk("R6 busy", v & 32'h40, 32'h40);
      polls = 0;
      while ((v & 32'h40) != 0 && polls < 60) begin
         rd(I_STAT, v);
         polls++;
      end
      chk("R6 status after flush", v, 32'h5);
      rd(I_LVL, v);  chk("R6 levels after flush", v, 32'h0);
      rd(I_CTRL, v); chk("R6 flush bit reads 0", v, 32'h0);
      wr(I_CTRL, 32'h1);
      wr(I_TXD, 32'h5A5A_0001);
      idle(40);
      rd(I_RXD, v); chk("R6 no stale word", v, 32'h5A5A_0001);
      rd(I_LVL, v); chk("R6 only new word moved", v, 32'h0);

      finish_run();
   end
endmodule